// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is the counting core of one timer channel. It holds a reload register and a down-counter, watches a gate input, and drives a single output whose waveform depends on the selected operating mode. Five modes are provided: terminal-count event (0), gate-triggered one-shot (1), rate generator (2), software-started strobe (3 is unused, 4) and gate-started strobe (5).

The block runs in one system clock domain. The slow timer clock does not enter as a clock: its active edge is presented as a single-cycle `tick` enable, and all loads and decrements happen only on cycles where `tick` is high. A bus front end is expected to sit in front of the block. It decodes control bytes into a mode number with a `mode_set` pulse, assembles full count values, and raises `load_req` when a count is complete. It holds `low_pending` high while a two-byte count has its first byte written and the second still missing.

Top module: `tmr_chan_core`

## Requirements
- R1: After reset, `out` is low, `count` is 0 and the channel is in mode 0 with no count loaded.
- R2: A reload value of 0 acts as a count of 2^WIDTH ticks.
- R3: On a cycle with `tick` low and no `mode_set`, `count` does not change.
- R4: Mode 0 (`mode` = 3'd0): `out` goes low on mode set and on every count write. The count loads on the first tick after the write. `out` rises on tick N+1 after a write of N and then stays high while the counter keeps wrapping.
- R5: In mode 0, `low_pending` high forces `out` low and halts counting. In modes 0, 2 and 4, a low gate level freezes the count.
- R6: Mode 1 (3'd1): `out` is high after mode set. A gate trigger loads the count and drives `out` low. `out` returns high when the count reaches 0, and a new trigger restarts the count.
- R7: Mode 2 (3'd2): a write of N while idle starts the count on the next tick. `out` is low for exactly the ticks where the count equals 1, so the period is N ticks. The count passes from 1 straight to the reload value and never shows 0. A low gate holds `out` high and stops counting.
- R8: Mode 4 (3'd4): counting starts one tick after a write. `out` drops for one tick when the count reaches 0, once per write. The gate level only enables counting and does not change `out`.
- R9: Mode 5 (3'd5): a gate trigger loads the count, and `out` pulses low for one tick when it reaches 0, once per trigger. With no trigger, `out` stays high.
- R10: In modes 1 and 2, a count written while a count is running changes nothing until the next trigger or wrap.
- R11: A gate trigger is a tick that sees the gate high when the previous tick saw it low. It acts on that same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable marking an active timer-clock edge |
| gate | input | 1 | Gate level |
| mode | input | 3 | Mode number, taken when `mode_set` is high |
| mode_set | input | 1 | Pulse: select `mode`, clear reload value and progress |
| load_req | input | 1 | Pulse: `reload` holds a complete new count |
| reload | input | WIDTH | Count value written by the front end |
| low_pending | input | 1 | First byte of a two-byte count written, second not yet |
| out | output | 1 | Channel output |
| count | output | WIDTH | Current counter value |

## Verification
The bench builds the channel with WIDTH set to 8. At that width the full-range count that a reload of 0 selects, and the wrap past zero in modes 0, 4 and 5, take only a few hundred cycles, so the bench checks both directly. Random tick densities and random counts in modes 0 and 2 check the N+1 delay and the N-tick period against bench functions. Directed sequences cover triggers, retriggers, writes made mid-count and gate levels.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5,
    MD_RSV6    = 3'd6,
    MD_RSV7    = 3'd7
  } mode_e;
endpackage

// File: rtl/tmr_gate_sense.sv
module tmr_gate_sense (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic gate,
  output logic rise
);
  logic gate_seen;

  always_ff @(posedge clk) begin
    if (rst) gate_seen <= 1'b1;
    else if (tick) gate_seen <= gate;
  end

  assign rise = gate & ~gate_seen;
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_load,
  input  logic             do_dec,
  input  logic             wrap_at_one,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] nxt,
  output logic             at_one
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assign at_one = (cnt == ONE);
  assign nxt    = (wrap_at_one && at_one) ? load_val : cnt - ONE;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (do_load) cnt <= load_val;
    else if (do_dec)  cnt <= nxt;
  end
endmodule

// File: rtl/tmr_chan_core.sv
module tmr_chan_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic [2:0]       mode,
  input  logic             mode_set,
  input  logic             load_req,
  input  logic [WIDTH-1:0] reload,
  input  logic             low_pending,
  output logic             out,
  output logic [WIDTH-1:0] count
);
  import tmr_chan_pkg::*;

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  mode_e            mode_r;
  logic             out_r, live, armed, load_pend, have_cnt;
  logic [WIDTH-1:0] reload_r, cnt, nxt;
  logic             at_one, rise, do_load, do_dec, wrap_at_one;

  tmr_gate_sense u_gate (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .rise(rise)
  );

  assign wrap_at_one = (mode_r == MD_RATE);

  tmr_count_unit #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .do_load(do_load), .do_dec(do_dec),
    .wrap_at_one(wrap_at_one), .load_val(reload_r),
    .cnt(cnt), .nxt(nxt), .at_one(at_one)
  );

  always_comb begin
    do_load = 1'b0;
    do_dec  = 1'b0;
    if (tick && !mode_set) begin
      case (mode_r)
        MD_TERM: begin
          do_load = load_pend;
          do_dec  = !load_pend && live && gate && !low_pending;
        end
        MD_ONESHOT, MD_HWSTB: begin
          do_load = rise;
          do_dec  = !rise;
        end
        MD_RATE: begin
          do_load = load_pend || (rise && have_cnt);
          do_dec  = !do_load && live && gate;
        end
        MD_SWSTB: begin
          do_load = load_pend;
          do_dec  = !load_pend && live && gate;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r    <= MD_TERM;
      out_r     <= 1'b0;
      live      <= 1'b0;
      armed     <= 1'b0;
      load_pend <= 1'b0;
      have_cnt  <= 1'b0;
      reload_r  <= '0;
    end else if (mode_set) begin
      mode_r    <= mode_e'(mode);
      out_r     <= (mode != 3'd0);
      live      <= 1'b0;
      armed     <= 1'b0;
      load_pend <= 1'b0;
      have_cnt  <= 1'b0;
      reload_r  <= '0;
    end else begin
      // tick effects first; later statements override them
      if (tick) begin
        if (mode_r == MD_SWSTB || mode_r == MD_HWSTB) out_r <= 1'b1;
        if (do_load) begin
          live      <= 1'b1;
          armed     <= 1'b1;
          load_pend <= 1'b0;
          if (mode_r == MD_ONESHOT) out_r <= 1'b0;
          if (mode_r == MD_RATE)    out_r <= 1'b1;
        end else if (do_dec) begin
          case (mode_r)
            MD_TERM, MD_ONESHOT:
              if (armed && at_one) begin
                out_r <= 1'b1;
                armed <= 1'b0;
              end
            MD_RATE: out_r <= (nxt != ONE);
            MD_SWSTB, MD_HWSTB:
              if (armed && at_one) begin
                out_r <= 1'b0;
                armed <= 1'b0;
              end
            default: ;
          endcase
        end
      end
      if (load_req) begin
        reload_r <= reload;
        have_cnt <= 1'b1;
        case (mode_r)
          MD_TERM: begin
            out_r     <= 1'b0;
            armed     <= 1'b0;
            load_pend <= 1'b1;
          end
          MD_SWSTB: begin
            armed     <= 1'b0;
            load_pend <= 1'b1;
          end
          MD_RATE: if (!live) load_pend <= 1'b1;
          default: ;
        endcase
      end
      if (mode_r == MD_TERM && low_pending) out_r <= 1'b0;
      if (mode_r == MD_RATE && !gate)       out_r <= 1'b1;
    end
  end

  assign out   = out_r;
  assign count = cnt;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             gate,
  input logic [2:0]       mode,
  input logic             mode_set,
  input logic             low_pending,
  input logic             out,
  input logic [WIDTH-1:0] count,
  input logic [2:0]       mode_q
);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !mode_set) |=> $stable(count));

  p_set_low_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_set && mode == 3'd0) |=> !out);

  p_set_high_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_set && (mode == 3'd1 || mode == 3'd2 || mode == 3'd4 || mode == 3'd5)) |=> out);

  p_pending_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_set && mode_q == 3'd0 && low_pending) |=> (!out && $stable(count)));

  p_gate_high_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode_set && mode_q == 3'd2 && !gate) |=> out);

  p_strobe_one_r8: assert property (@(posedge clk) disable iff (rst)
    (!mode_set && (mode_q == 3'd4 || mode_q == 3'd5) && tick && !out) |=> out);
endmodule

bind tmr_chan_core tmr_chan_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .gate(gate), .mode(mode),
  .mode_set(mode_set), .low_pending(low_pending), .out(out),
  .count(count), .mode_q(mode_r)
);

// File: tb/tmr_chan_core_bench.sv
module tmr_chan_core_bench;
  localparam int W = 8;
  localparam int FULL = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b1;
  logic         gate = 1'b1;
  logic [2:0]   mode = 3'd0;
  logic         mode_set = 1'b0;
  logic         load_req = 1'b0;
  logic [W-1:0] reload = '0;
  logic         low_pending = 1'b0;
  logic         out;
  logic [W-1:0] count;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tmr_chan_core #(.WIDTH(W)) u_tmr_chan_core (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .mode(mode),
    .mode_set(mode_set), .load_req(load_req), .reload(reload),
    .low_pending(low_pending), .out(out), .count(count)
  );

  function automatic int exp_term_ticks(int n);
    return (n == 0) ? FULL + 1 : n + 1;
  endfunction

  function automatic int exp_rate_period(int n);
    return (n == 0) ? FULL : n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic set_mode(int m);
    mode = 3'(m); mode_set = 1'b1; step(); mode_set = 1'b0;
  endtask

  task automatic write_cnt(int n);
    reload = W'(n); load_req = 1'b1; step(); load_req = 1'b0;
  endtask

  task automatic trigger();
    gate = 1'b0; step(); gate = 1'b1; step();
  endtask

  task automatic ticks_to_rise(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      step();
      if (tick) n++;
      if (out) break;
    end
  endtask

  task automatic run_lows(int len, output int lows, output int first);
    lows = 0; first = -1;
    for (int i = 1; i <= len; i++) begin
      step();
      if (!out) begin
        lows++;
        if (first < 0) first = i;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, lows, first, c, mn, prev, started;
    void'($urandom(32'd1234));
    step(); step(); rst = 1'b0; step();
    chk("R1 out", out, 0);
    chk("R1 count", count, 0);

    // mode 0 timing
    set_mode(0);
    chk("R4 out after set", out, 0);
    write_cnt(5);
    chk("R4 out after write", out, 0);
    ticks_to_rise(n);
    chk("R4 ticks to rise", n, exp_term_ticks(5));
    run_lows(300, lows, first);
    chk("R4 stays high over wrap", lows, 0);

    // tick gating, low_pending, gate level
    write_cnt(9); step(); step();
    chk("R4 loaded and counting", count, 8);
    tick = 1'b0; c = count;
    repeat (5) step();
    chk("R3 count without tick", count, c);
    tick = 1'b1;
    low_pending = 1'b1; c = count;
    repeat (4) step();
    chk("R5 halted by low_pending", count, c);
    chk("R5 out low", out, 0);
    low_pending = 1'b0; gate = 1'b0; c = count;
    repeat (4) step();
    chk("R5 gate freeze", count, c);
    gate = 1'b1; step();

    // full range in mode 0
    write_cnt(0);
    ticks_to_rise(n);
    chk("R2 zero reload in mode 0", n, exp_term_ticks(0));

    // mode 1
    set_mode(1);
    chk("R6 out after set", out, 1);
    write_cnt(4);
    repeat (3) step();
    chk("R6 no trigger keeps out high", out, 1);
    trigger();
    chk("R11 trigger loads", count, 4);
    chk("R6 out low on trigger", out, 0);
    step(); step();
    gate = 1'b0; step(); gate = 1'b1; step();
    chk("R6 retrigger reloads", count, 4);
    chk("R6 retrigger out", out, 0);
    write_cnt(9);
    ticks_to_rise(n);
    chk("R10 mode 1 write mid-count", n, 3);
    trigger();
    chk("R10 new value at next trigger", count, 9);

    // mode 2
    set_mode(2);
    chk("R7 out after set", out, 1);
    write_cnt(4);
    step();
    chk("R7 loaded", count, 4);
    mn = FULL;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!out) lows++;
      if (count < mn) mn = count;
    end
    chk("R7 lows per 20 ticks", lows, 5);
    chk("R7 count never zero", mn, 1);
    gate = 1'b0; step();
    chk("R7 gate low out high", out, 1);
    c = count;
    repeat (3) step();
    chk("R7 gate low stops count", count, c);
    gate = 1'b1; step();
    chk("R11 gate rise reloads", count, 4);
    write_cnt(6);
    step();
    chk("R10 old count continues", count, 2);
    step(); step();
    chk("R10 wrap picks new value", count, 6);

    // full period with zero reload
    set_mode(2);
    write_cnt(0);
    prev = 1; started = 0; n = 0;
    for (int i = 0; i < 700 && started < 2; i++) begin
      step();
      n++;
      if (prev && !out) begin
        if (started == 1) chk("R2 zero reload period", n, exp_rate_period(0));
        started++;
        n = 0;
      end
      prev = out;
    end

    // mode 4
    set_mode(4);
    chk("R8 out after set", out, 1);
    write_cnt(3);
    run_lows(300, lows, first);
    chk("R8 single strobe", lows, 1);
    chk("R8 strobe position", first, 4);
    gate = 1'b0;
    write_cnt(3);
    run_lows(10, lows, first);
    chk("R8 gate low no strobe", lows, 0);
    chk("R8 gate low holds count", count, 3);
    gate = 1'b1;

    // mode 5
    set_mode(5);
    write_cnt(2);
    run_lows(5, lows, first);
    chk("R9 no trigger no strobe", lows, 0);
    trigger();
    chk("R9 trigger loads", count, 2);
    run_lows(20, lows, first);
    chk("R9 one strobe", lows, 1);
    chk("R9 strobe position", first, 2);
    trigger();
    run_lows(20, lows, first);
    chk("R9 second trigger strobe", lows, 1);

    // random tick density, mode 0
    set_mode(0);
    for (int k = 0; k < 20; k++) begin
      int nv;
      nv = 1 + int'($urandom % 40);
      tick = 1'b1;
      write_cnt(nv);
      n = 0;
      for (int i = 0; i < 2000; i++) begin
        tick = ($urandom % 3) != 0;
        step();
        if (tick) n++;
        if (out) break;
      end
      chk("R4 random ticks to rise", n, exp_term_ticks(nv));
    end

    // random tick density, mode 2
    for (int k = 0; k < 10; k++) begin
      int nv;
      nv = 2 + int'($urandom % 19);
      tick = 1'b1;
      set_mode(2);
      write_cnt(nv);
      prev = 1; started = 0; n = 0;
      for (int i = 0; i < 3000 && started < 2; i++) begin
        tick = ($urandom % 2) != 0;
        step();
        if (tick) n++;
        if (prev && !out) begin
          if (started == 1) chk("R7 random period", n, exp_rate_period(nv));
          started++;
          n = 0;
        end
        prev = out;
      end
      chk("R7 random saw two strobes", started, 2);
    end
    tick = 1'b1;

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule